// File: doc/BRIEF.md
# Configurable Framing Serial Transmitter

This block sends data words one at a time on a single serial line. A word goes into a one-entry holding register through a write strobe. When the line is free and the far end allows sending, the word moves into a shift register and goes out as an asynchronous frame. The frame starts with a low start bit, then carries the data bits least-significant first, then an optional parity bit, and ends with one or two high stop bits. An external divisor supplies a baud-tick pulse, and each bit lasts a fixed number of these ticks.

The framing is set at run time by a small group of control inputs: word length from 5 to 8 bits, one or two stop bits, and a parity mode. The parity modes are none, even, odd, and the two stick modes (parity always 1 or always 0). A break input holds the line low for as long as it is set. Two status outputs show whether the holding register is free and whether the whole transmitter is idle. The surrounding logic uses them to pace its writes.

Top module: `uart_frame_tx`

## Requirements
- R1: A frame is a low start bit, then the data bits least-significant first, then the parity bit if enabled, then the stop bits at high level. Each bit lasts TICKS_PER_BIT (default 16) baud ticks, counted from the cycle the word is loaded.
- R2: `cfg_wlen` selects the data bit count: 2'b00 gives 5, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8. Unused upper bits of `wr_data` are not sent.
- R3: `cfg_two_stop` = 0 sends one stop bit; `cfg_two_stop` = 1 sends two.
- R4: When `cfg_par_en` = 0 no parity bit is sent. When `cfg_par_en` = 1 and `cfg_stick` = 0, `cfg_even_sel` = 1 selects even parity (the parity bit equals the XOR of the sent data bits) and `cfg_even_sel` = 0 selects odd parity (its inverse). When `cfg_par_en` = 1 and `cfg_stick` = 1, the parity bit is the inverse of `cfg_even_sel`: 1 (mark) for `cfg_even_sel` = 0 and 0 (space) for `cfg_even_sel` = 1.
- R5: While `cfg_break` = 1, `txd` is 0 in the same cycle, whether the transmitter is idle or sending.
- R6: `hold_empty` falls in the cycle after a write and rises in the cycle after the word moves into the shifter. `tx_empty` is 1 only when the holding register is empty and no frame is in progress.
- R7: While `cts_n` = 1, no new word is loaded into the shifter. The pending word stays in the holding register and `txd` stays idle.
- R8: When no frame is in progress and break is off, `txd` is 1.
- R9: A write while the holding register is full replaces the pending word. A frame already in progress is sent unchanged.
- R10: After reset `txd` = 1, `hold_empty` = 1 and `tx_empty` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_tick | input | 1 | One-cycle pulse from the external baud divisor |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Word to send |
| cfg_wlen | input | 2 | Word length select (5 to 8 bits) |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| cfg_par_en | input | 1 | Parity enable |
| cfg_even_sel | input | 1 | Even parity select (inverted as the stick value) |
| cfg_stick | input | 1 | Stick parity enable |
| cfg_break | input | 1 | Force the line low |
| cts_n | input | 1 | Clear to send, active low |
| txd | output | 1 | Serial output |
| hold_empty | output | 1 | Holding register free |
| tx_empty | output | 1 | Holding register and shifter both idle |

## Verification
The bench decodes frames across random mixes of word length, stop count and all five parity modes. A wrong field decode, a reversed bit order or an inverted parity sense would show up as a corrupted frame or a frame of the wrong length. It holds clear-to-send high while writing twice, so a gate that leaks would start a frame early, and a holding register that keeps the first word would send stale data. It writes twice during a frame in progress, which catches a shifter that reloads from the holding register in mid-frame. It also asserts break both at idle and in mid-frame, which catches a break that is only sampled between frames.

// File: rtl/uart_ftx_pkg.sv
package uart_ftx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic [1:0] wlen;
        logic       two_stop;
        logic       par_en;
        logic       even_sel;
        logic       stick;
    } frame_cfg_t;

    localparam int WORD_W = 8;

    // number of data bits selected by the word-length field
    function automatic logic [3:0] data_bits(input logic [1:0] wlen);
        return 4'd5 + {2'b00, wlen};
    endfunction

    // parity bit for the word under the given framing
    function automatic logic parity_bit(input logic [WORD_W-1:0] d, input frame_cfg_t c);
        logic [WORD_W-1:0] m;
        m = d & (8'hFF >> (4'd8 - data_bits(c.wlen)));
        if (c.stick)
            return ~c.even_sel;
        return c.even_sel ? (^m) : ~(^m);
    endfunction

endpackage

// File: rtl/uart_ftx_hold.sv
module uart_ftx_hold
    import uart_ftx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              load,
    output logic              full,
    output logic [WORD_W-1:0] data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
        end else begin
            if (load)
                full <= 1'b0;
            // a write in the same cycle as a load refills the register
            if (wr_stb) begin
                full <= 1'b1;
                data <= wr_data;
            end
        end
    end

endmodule

// File: rtl/uart_ftx_shifter.sv
module uart_ftx_shifter
    import uart_ftx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              cts_n,
    input  logic              hold_full,
    input  logic [WORD_W-1:0] hold_data,
    input  frame_cfg_t        cfg,
    output logic              load,
    output logic              busy,
    output logic              line_bit
);

    localparam int CNT_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
    localparam logic [CNT_W-1:0] TCNT_LAST = CNT_W'(TICKS_PER_BIT - 1);

    tx_state_e         state;
    logic [CNT_W-1:0]  tcnt;
    logic [WORD_W-1:0] shreg;
    logic [3:0]        bitcnt;
    logic [3:0]        nbits;
    logic              par_r;
    logic              par_en_r;
    logic              two_stop_r;
    logic              bit_end;

    assign load    = (state == ST_IDLE) && hold_full && !cts_n;
    assign busy    = (state != ST_IDLE);
    assign bit_end = baud_tick && (tcnt == TCNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            tcnt       <= '0;
            shreg      <= '0;
            bitcnt     <= '0;
            nbits      <= 4'd8;
            par_r      <= 1'b0;
            par_en_r   <= 1'b0;
            two_stop_r <= 1'b0;
        end else if (load) begin
            state      <= ST_START;
            tcnt       <= '0;
            shreg      <= hold_data;
            bitcnt     <= '0;
            nbits      <= data_bits(cfg.wlen);
            par_r      <= parity_bit(hold_data, cfg);
            par_en_r   <= cfg.par_en;
            two_stop_r <= cfg.two_stop;
        end else if (busy && baud_tick) begin
            tcnt <= bit_end ? '0 : tcnt + 1'b1;
            if (bit_end) begin
                unique case (state)
                    ST_START: begin
                        state  <= ST_DATA;
                        bitcnt <= '0;
                    end
                    ST_DATA: begin
                        shreg <= shreg >> 1;
                        if (bitcnt == nbits - 4'd1) begin
                            state  <= par_en_r ? ST_PAR : ST_STOP;
                            bitcnt <= '0;
                        end else begin
                            bitcnt <= bitcnt + 4'd1;
                        end
                    end
                    ST_PAR: begin
                        state  <= ST_STOP;
                        bitcnt <= '0;
                    end
                    ST_STOP: begin
                        if (two_stop_r && bitcnt == 4'd0)
                            bitcnt <= 4'd1;
                        else
                            state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        unique case (state)
            ST_START: line_bit = 1'b0;
            ST_DATA:  line_bit = shreg[0];
            ST_PAR:   line_bit = par_r;
            default:  line_bit = 1'b1;
        endcase
    end

endmodule

// File: rtl/uart_ftx_line.sv
module uart_ftx_line (
    input  logic line_bit,
    input  logic force_space,
    output logic txd
);

    assign txd = force_space ? 1'b0 : line_bit;

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uart_ftx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       baud_tick,
    input  logic       wr_stb,
    input  logic [7:0] wr_data,
    input  logic [1:0] cfg_wlen,
    input  logic       cfg_two_stop,
    input  logic       cfg_par_en,
    input  logic       cfg_even_sel,
    input  logic       cfg_stick,
    input  logic       cfg_break,
    input  logic       cts_n,
    output logic       txd,
    output logic       hold_empty,
    output logic       tx_empty
);

    frame_cfg_t        cfg;
    logic              load;
    logic              busy;
    logic              line_bit;
    logic              hold_full;
    logic [WORD_W-1:0] hold_data;

    assign cfg = '{wlen: cfg_wlen, two_stop: cfg_two_stop, par_en: cfg_par_en,
                   even_sel: cfg_even_sel, stick: cfg_stick};

    uart_ftx_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .load    (load),
        .full    (hold_full),
        .data    (hold_data)
    );

    uart_ftx_shifter #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .baud_tick (baud_tick),
        .cts_n     (cts_n),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .cfg       (cfg),
        .load      (load),
        .busy      (busy),
        .line_bit  (line_bit)
    );

    uart_ftx_line u_line (
        .line_bit    (line_bit),
        .force_space (cfg_break),
        .txd         (txd)
    );

    assign hold_empty = !hold_full;
    assign tx_empty   = !hold_full && !busy;

endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
    input logic clk,
    input logic rst,
    input logic wr_stb,
    input logic cfg_break,
    input logic cts_n,
    input logic txd,
    input logic hold_empty,
    input logic tx_empty
);

    assert_break_low_R5: assert property (@(posedge clk) disable iff (rst)
        cfg_break |-> !txd);

    assert_idle_high_R8: assert property (@(posedge clk) disable iff (rst)
        (tx_empty && !cfg_break) |-> txd);

    assert_cts_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (cts_n && !hold_empty) |=> !hold_empty);

    assert_temt_needs_hold_R6: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> hold_empty);

    assert_load_busy_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_empty) |-> !tx_empty);

    assert_write_fills_R6: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !hold_empty);

endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_stb     (wr_stb),
    .cfg_break  (cfg_break),
    .cts_n      (cts_n),
    .txd        (txd),
    .hold_empty (hold_empty),
    .tx_empty   (tx_empty)
);

// File: tb/tb_uart_frame_tx.sv
`timescale 1ns/1ps
module tb_uart_frame_tx;

    logic       clk = 1'b0;
    logic       rst;
    logic       baud_tick = 1'b0;
    logic       wr_stb;
    logic [7:0] wr_data;
    logic [1:0] cfg_wlen;
    logic       cfg_two_stop, cfg_par_en, cfg_even_sel, cfg_stick, cfg_break;
    logic       cts_n;
    logic       txd, hold_empty, tx_empty;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;   // 125 MHz

    // one baud tick every two clocks: one bit = 16 ticks = 32 clocks
    always @(negedge clk) baud_tick <= ~baud_tick;

    uart_frame_tx dut (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .wr_stb(wr_stb), .wr_data(wr_data),
        .cfg_wlen(cfg_wlen), .cfg_two_stop(cfg_two_stop), .cfg_par_en(cfg_par_en),
        .cfg_even_sel(cfg_even_sel), .cfg_stick(cfg_stick), .cfg_break(cfg_break),
        .cts_n(cts_n), .txd(txd), .hold_empty(hold_empty), .tx_empty(tx_empty)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // expected frame, bit 0 first on the line; unused positions are 1
    function automatic int exp_frame(input logic [7:0] d, input logic [1:0] wl, input logic ts,
                                     input logic pe, input logic es, input logic sk,
                                     output logic [11:0] bits);
        int nb = 5 + int'(wl);
        int idx;
        logic ones = 1'b0;
        bits = '1;
        bits[0] = 1'b0;
        for (int i = 0; i < nb; i++) begin
            bits[1+i] = d[i];
            ones ^= d[i];
        end
        idx = 1 + nb;
        if (pe) begin
            bits[idx] = sk ? ~es : (es ? ones : ~ones);
            idx++;
        end
        idx += ts ? 2 : 1;
        return idx;
    endfunction

    task automatic capture(input int n, output logic [11:0] got);
        int guard = 0;
        got = '1;
        @(negedge clk);
        while (txd !== 1'b0 && guard < 4000) begin
            @(negedge clk);
            guard++;
        end
        repeat (16) @(negedge clk);
        got[0] = txd;
        for (int i = 1; i < n; i++) begin
            repeat (32) @(negedge clk);
            got[i] = txd;
        end
    endtask

    task automatic write_word(input logic [7:0] d);
        wr_data = d;
        wr_stb  = 1'b1;
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    task automatic set_cfg(input logic [1:0] wl, input logic ts, input logic pe,
                           input logic es, input logic sk);
        cfg_wlen = wl; cfg_two_stop = ts; cfg_par_en = pe; cfg_even_sel = es; cfg_stick = sk;
    endtask

    task automatic send_and_check(input string req, input logic [7:0] d);
        logic [11:0] exp_b, got_b;
        int n;
        n = exp_frame(d, cfg_wlen, cfg_two_stop, cfg_par_en, cfg_even_sel, cfg_stick, exp_b);
        write_word(d);
        capture(n, got_b);
        check(req, 32'(got_b), 32'(exp_b));
        repeat (24) @(negedge clk);
        check("R6 tx_empty after frame", 32'(tx_empty), 32'd1);
    endtask

    initial begin
        logic [11:0] exp_b, got_b, got_c;
        int n;
        int seed;
        rst = 1'b1; wr_stb = 1'b0; wr_data = '0; cfg_break = 1'b0; cts_n = 1'b0;
        set_cfg(2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 txd", 32'(txd), 32'd1);
        check("R10 hold_empty", 32'(hold_empty), 32'd1);
        check("R10 tx_empty", 32'(tx_empty), 32'd1);
        repeat (40) @(negedge clk);
        check("R8 idle high", 32'(txd), 32'd1);

        // directed framing corners
        set_cfg(2'b11, 1'b0, 1'b0, 1'b0, 1'b0); send_and_check("R1 8N1", 8'hA5);
        set_cfg(2'b00, 1'b0, 1'b0, 1'b0, 1'b0); send_and_check("R2 5 bits", 8'hF3);
        set_cfg(2'b01, 1'b1, 1'b0, 1'b0, 1'b0); send_and_check("R2/R3 6 bits 2 stop", 8'h2D);
        set_cfg(2'b11, 1'b0, 1'b1, 1'b1, 1'b0); send_and_check("R4 even", 8'h07);
        set_cfg(2'b11, 1'b0, 1'b1, 1'b0, 1'b0); send_and_check("R4 odd", 8'h07);
        set_cfg(2'b10, 1'b0, 1'b1, 1'b0, 1'b1); send_and_check("R4 mark", 8'h00);
        set_cfg(2'b10, 1'b1, 1'b1, 1'b1, 1'b1); send_and_check("R4 space", 8'hFF);

        // break at idle
        cfg_break = 1'b1;
        #1 check("R5 break idle", 32'(txd), 32'd0);
        repeat (50) @(negedge clk);
        check("R5 break held", 32'(txd), 32'd0);
        cfg_break = 1'b0;
        #1 check("R8 after break", 32'(txd), 32'd1);

        // break in mid-frame, frame then completes
        set_cfg(2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
        write_word(8'hFF);
        repeat (100) @(negedge clk);
        cfg_break = 1'b1;
        #1 check("R5 break mid-frame", 32'(txd), 32'd0);
        repeat (60) @(negedge clk);
        check("R5 break mid-frame held", 32'(txd), 32'd0);
        cfg_break = 1'b0;
        repeat (300) @(negedge clk);
        check("R6 idle after break frame", 32'(tx_empty), 32'd1);

        // clear-to-send gating and overwrite of a pending word
        cts_n = 1'b1;
        write_word(8'hA5);
        check("R6 hold_empty after write", 32'(hold_empty), 32'd0);
        repeat (100) @(negedge clk);
        check("R7 pending held", 32'(hold_empty), 32'd0);
        check("R7 line idle", 32'(txd), 32'd1);
        check("R6 tx_empty busy", 32'(tx_empty), 32'd0);
        write_word(8'h3C);
        n = exp_frame(8'h3C, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, exp_b);
        cts_n = 1'b0;
        capture(n, got_b);
        check("R9 overwrite pending", 32'(got_b), 32'(exp_b));
        repeat (24) @(negedge clk);

        // writes during a frame in progress
        write_word(8'h11);
        @(negedge clk);
        check("R6 hold_empty after load", 32'(hold_empty), 32'd1);
        check("R6 tx_empty while shifting", 32'(tx_empty), 32'd0);
        fork
            capture(10, got_b);
            begin
                repeat (60) @(negedge clk);
                write_word(8'h22);
                write_word(8'h33);
            end
        join
        n = exp_frame(8'h11, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, exp_b);
        check("R9 frame in progress intact", 32'(got_b), 32'(exp_b));
        capture(10, got_c);
        n = exp_frame(8'h33, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, exp_b);
        check("R9 last write sent", 32'(got_c), 32'(exp_b));
        repeat (24) @(negedge clk);

        // random framings
        seed = $urandom(32'h5EED);
        for (int k = 0; k < 24; k++) begin
            logic [5:0] r;
            r = 6'($urandom);
            set_cfg(r[1:0], r[2], r[3], r[4], r[5]);
            send_and_check("R1/R2/R3/R4 random", 8'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule